// File: doc/BRIEF.md
# Free-Running Bus Timer with Tear-Free Byte Reads

This block is a free-running up-counter for a small controller with an 8-bit register bus. A fixed divide-by-four prescaler, fed by the bus clock, advances the count. The count runs without pause from reset. Software reads it as two byte registers. A read of the upper byte freezes the lower byte in a holding register, and the later read of the lower byte releases it. The two reads therefore return one coherent value even when a carry crosses the byte boundary between them.

On rollover a status flag is set. When the enable bit in the control register is set, the flag drives the interrupt request line. Software clears the flag with two reads: first the status register while the flag is set, then the lower count byte. The register port has one-cycle read and write strobes. Read data is combinational from the address.

Top module: `ftmr_top`

## Requirements
- R1: The count increases by exactly one at the clock edge that ends every fourth cycle after reset release, and holds at all other edges.
- R2: The count wraps from its all-ones value to zero. At the default 16-bit width the full period is 262,144 clock cycles; for width W it is 4·2^W.
- R3: Register reads, in any number and order, never alter the counting sequence.
- R4: Reading the upper byte (0x18) captures the lower byte at that moment. A later read of the lower byte (0x19) returns the captured value and reopens the holding register. When no capture is pending, a lower-byte read returns the live lower byte.
- R5: The register map is as follows:
  - control at 0x12, with interrupt enable at bit 5;
  - status at 0x13, with the overflow flag at bit 5 and all other bits 0;
  - count upper byte at 0x18, zero-extended when the width is below 16;
  - count lower byte at 0x19;
  - any other address reads 0.
- R6: The overflow flag is set at the edge where the count wraps.
- R7: The flag is cleared only by a lower-byte read that follows a status read made while the flag was set. An overflow in the same cycle as that clearing read keeps the flag set. A status read alone does not clear it.
- R8: The interrupt request output is high exactly when the overflow flag and the enable bit are both set.
- R9: Writes to the status and count addresses are ignored. A write to the control address takes effect at the next edge and reads back.
- R10: After reset, the following hold:
  - the count is zero;
  - the flag is clear;
  - the control register is zero;
  - the interrupt request is low;
  - the holding register is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Read data is due in the same cycle as the strobe and is sampled one nanosecond after the falling edge. Side effects of a read or write appear only after the next rising edge: latch capture, latch release, flag clear, and the control update together with its effect on the interrupt line. Those effects are observed at the following falling edge. The bench's expected count is the number of rising edges since reset release divided by four. Every count read is therefore compared against the value that register path should show in exactly that cycle. The carry-straddling pairs and the overflow-coincident clear are timed against that same edge count.

// File: rtl/ftmr_pkg.sv
package ftmr_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h12;
  localparam logic [7:0] ADDR_STAT = 8'h13;
  localparam logic [7:0] ADDR_CNTH = 8'h18;
  localparam logic [7:0] ADDR_CNTL = 8'h19;
  localparam int unsigned FLAG_BIT = 5;
endpackage

// File: rtl/ftmr_prescaler.sv
module ftmr_prescaler #(
  parameter int unsigned DIV_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [DIV_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  assign tick_o = &pre_q;

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R1
endmodule

// File: rtl/ftmr_counter.sv
module ftmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hi_rd_i,
  input  logic             lo_rd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       lo_view_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       hold_q;
  logic             held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // holding register: closed by upper read, reopened by lower read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      hold_q <= '0;
    end else if (hi_rd_i) begin
      held_q <= 1'b1;
      hold_q <= cnt_q[7:0];
    end else if (lo_rd_i) begin
      held_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign lo_view_o = held_q ? hold_q : cnt_q[7:0];
  assign wrap_o    = tick_i & (&cnt_q);

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (&cnt_q)) |=> (cnt_q == '0)); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R3
  AST_LATCH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !lo_rd_i && !hi_rd_i) |=> (held_q && $stable(hold_q))); // R4
endmodule

// File: rtl/ftmr_flag.sv
module ftmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic stat_rd_i,
  input  logic lo_rd_i,
  output logic flag_o
);
  logic flag_q;
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (wrap_i)             flag_q <= 1'b1; // set wins over clear
    else if (armed_q && lo_rd_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    armed_q <= 1'b0;
    else if (lo_rd_i)               armed_q <= 1'b0;
    else if (stat_rd_i && flag_q)   armed_q <= 1'b1;
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> flag_o); // R6
  AST_CLEAR_BY_LOW_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !lo_rd_i) |=> flag_o); // R7
endmodule

// File: rtl/ftmr_top.sv
module ftmr_top
  import ftmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  localparam int unsigned HI_W = CNT_W - 8;

  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       lo_view;
  logic [7:0]       hi_byte;
  logic [7:0]       ctrl_q;
  logic             wrap;
  logic             flag;
  logic             hi_rd, lo_rd, stat_rd, ctrl_wr;

  assign hi_rd   = rd_i && (addr_i == ADDR_CNTH);
  assign lo_rd   = rd_i && (addr_i == ADDR_CNTL);
  assign stat_rd = rd_i && (addr_i == ADDR_STAT);
  assign ctrl_wr = wr_i && (addr_i == ADDR_CTRL);

  ftmr_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  ftmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .hi_rd_i  (hi_rd),
    .lo_rd_i  (lo_rd),
    .cnt_o    (cnt),
    .lo_view_o(lo_view),
    .wrap_o   (wrap)
  );

  ftmr_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap),
    .stat_rd_i(stat_rd),
    .lo_rd_i  (lo_rd),
    .flag_o   (flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata_i;
  end

  always_comb begin
    hi_byte = '0;
    hi_byte[HI_W-1:0] = cnt[CNT_W-1:8];
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_STAT: rdata_o[FLAG_BIT] = flag;
      ADDR_CNTH: rdata_o = hi_byte;
      ADDR_CNTL: rdata_o = lo_view;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = flag & ctrl_q[FLAG_BIT];

  AST_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i != ADDR_CTRL)) |=> $stable(ctrl_q)); // R9
  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(wrap) || $past(ctrl_wr))); // R8
endmodule

// File: tb/ftmr_top_test.sv
`timescale 1ns/1ps
module ftmr_top_test;
  localparam int unsigned CW  = 12;
  localparam int unsigned PER = 4 * (1 << CW);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  int n_edge = 0;
  bit done   = 0;

  // {target low byte, prescaler phase, gap cycles between reads}
  localparam logic [13:0] TBL [6] = '{
    {8'hFF, 2'd3, 4'd0},
    {8'hFF, 2'd3, 4'd5},
    {8'hFF, 2'd2, 4'd1},
    {8'h7F, 2'd0, 4'd3},
    {8'h00, 2'd1, 4'd0},
    {8'hFF, 2'd3, 4'd15}
  };

  ftmr_top #(.CNT_W(CW), .DIV_W(2)) uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .rd_i   (rd),
    .wr_i   (wr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) n_edge <= n_edge + 1;

  function automatic int exp_cnt();
    return (n_edge / 4) % (1 << CW);
  endfunction

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic rd_byte(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic pair(input int gap, input string req);
    logic [7:0] h, l;
    int e;
    e = exp_cnt();
    rd_byte(8'h18, h);
    idle(gap);
    rd_byte(8'h19, l);
    chk(req, {h, l}, e);
  endtask

  task automatic wait_n(input int target);
    while (n_edge != target) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d, a0, a1;
    int e;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state (n_edge = 1 here)
    chk("R10 irq", irq, 0);
    rd_byte(8'h12, d); chk("R10 ctrl", d, 0);
    rd_byte(8'h13, d); chk("R10 status", d, 0);
    pair(0, "R10 count");
    rd_byte(8'h14, d); chk("R5 unmapped", d, 0);

    // table of pair reads, including carry straddles (R4, R3)
    foreach (TBL[k]) begin
      while (!(((exp_cnt() & 255) == int'(TBL[k][13:6])) && ((n_edge % 4) == int'(TBL[k][5:4]))))
        @(negedge clk);
      pair(int'(TBL[k][3:0]), "R4 pair read");
    end

    // R4 live lower byte with no capture pending
    e = exp_cnt() & 255;
    rd_byte(8'h19, d); chk("R4 live low", d, e);
    // R4 hold over a long gap
    pair(40, "R4 long hold");

    // R1 step timing
    while ((n_edge % 4) != 0) @(negedge clk);
    rd_byte(8'h19, a0); rd_byte(8'h19, a1);
    chk("R1 no step mid-period", a1, a0);
    while ((n_edge % 4) != 3) @(negedge clk);
    rd_byte(8'h19, a0); rd_byte(8'h19, a1);
    chk("R1 step on fourth edge", a1, (a0 + 1) & 255);

    // R9 writes to read-only registers ignored
    wr_byte(8'h18, 8'hAB);
    wr_byte(8'h19, 8'hCD);
    wr_byte(8'h13, 8'hFF);
    pair(0, "R9 count untouched");
    rd_byte(8'h13, d); chk("R9 status untouched", d, 0);
    rd_byte(8'h12, d); chk("R9 ctrl untouched", d, 0);

    // R2 / R6 first wrap
    wait_n(PER - 2);
    pair(0, "R2 before wrap");
    pair(0, "R2 after wrap");
    rd_byte(8'h13, d); chk("R6 flag set", d, 8'h20);
    chk("R8 irq off when disabled", irq, 0);
    wr_byte(8'h12, 8'h20);
    chk("R8 irq on when enabled", irq, 1);
    rd_byte(8'h12, d); chk("R9 ctrl readback", d, 8'h20);

    // R7 clear sequence
    rd_byte(8'h13, d);
    rd_byte(8'h19, d);
    chk("R7 cleared irq", irq, 0);
    rd_byte(8'h13, d); chk("R7 cleared status", d, 0);

    // R7 status read alone does not clear
    wait_n(2 * PER + 4);
    rd_byte(8'h13, d); chk("R6 second wrap", d, 8'h20);
    idle(5);
    rd_byte(8'h13, d); chk("R7 status read alone", d, 8'h20);

    // R7 overflow coincident with clearing read keeps flag
    wait_n(3 * PER - 1);
    rd_byte(8'h19, d);
    rd_byte(8'h13, d); chk("R7 set beats clear", d, 8'h20);
    chk("R8 irq held", irq, 1);
    rd_byte(8'h19, d);
    rd_byte(8'h13, d); chk("R7 clear after coincidence", d, 0);
    pair(2, "R3 count after traffic");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule